// File: doc/BRIEF.md
# Mixed-Signal Boundary-Scan Test Controller

This block is the digital test logic of a small mixed-signal device that carries a four-wire serial test port. It runs the sixteen-state test port controller, an 8-bit instruction register, a one-bit bypass path and a 14-bit boundary chain. The chain holds a 4-bit control word for the interface between the external analog test pins and the internal analog test buses, one 4-bit word for an analog input pin cell, one for an analog output pin cell, and one bit each for a digital input cell and a digital output cell.

The analog switches, the pin comparators and the core circuits live outside the block. The block decodes each analog cell word into five switch enables (core link, drive high, drive low, bus 1, bus 2) that depend on the active instruction. It also steers the two digital cells between transparent and test-driven operation. The comparator results enter the chain as captured bits.

Top module: `mxs_scan_ctrl`

## Requirements
- R1: An active-low `trst_n` or five consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset. Reset loads the all-ones instruction (bypass), clears every update latch and returns all pins to mission connection.
- R2: In Capture-IR the instruction shift stage loads 0x01. During Shift-IR the register shifts toward TDO, least significant bit first, so the first bit out is 1 and the next seven are 0.
- R3: The instruction 0xFF, and any code other than 0x00, 0x01 and 0x02, selects the one-bit bypass path. That path captures 0 and delays TDI by one TCK cycle.
- R4: The codes 0x00 (isolate test), 0x01 (probe) and 0x02 (sample/preload) select the 14-bit boundary chain. Bit i is the i-th bit to leave on TDO. Bit 0 is the digital output cell and bit 1 the digital input cell. Bits 5:2 are the analog output cell, bits 9:6 the analog input cell and bits 13:10 the interface control word.
- R5: Within each 4-bit analog cell word {D,C,B1,B2}, D is the highest bit. Capture-DR loads the pin comparator into D and 0 into C, B1 and B2. The digital output cell captures `core_dout`, the digital input cell captures `dig_pin_in`, and the interface word captures 0.
- R6: The update latches, and therefore the decoded outputs, change only when the controller leaves Update-DR. Shifting, pausing and capturing leave them unchanged.
- R7: Under isolate test (0x00), each analog switch vector `{core,hi,lo,bus1,bus2}` is {0, C&D, C&~D, B1, B2}. `ifc_ctl` shows the latched interface word, `dig_pin_out` shows the latched output cell and `core_din` shows the latched input cell.
- R8: Under probe (0x01), an analog cell whose D and C are both 0 gives {1,0,0,B1,B2}, and a cell with D or C set gives {1,0,0,0,0}. `ifc_ctl` shows the latched interface word. The digital cells are transparent: `dig_pin_out`=`core_dout` and `core_din`=`dig_pin_in`.
- R9: Under sample/preload, bypass or an unknown code, both analog vectors are {1,0,0,0,0}, `ifc_ctl` is 0 and the digital cells are transparent. Values preloaded in this mode take effect once isolate test is loaded.
- R10: TDO changes only on the falling edge of TCK. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for tdo |
| ain_cmp | input | 1 | Comparator result of the analog input pin |
| aout_cmp | input | 1 | Comparator result of the analog output pin |
| dig_pin_in | input | 1 | Level at the digital input pin |
| core_dout | input | 1 | Core value for the digital output pin |
| core_din | output | 1 | Value handed to the core from the digital input cell |
| dig_pin_out | output | 1 | Value driven on the digital output pin |
| ifc_ctl | output | 4 | Interface switch control word (zero in mission) |
| ain_sw | output | 5 | Analog input pin switches {core,hi,lo,bus1,bus2} |
| aout_sw | output | 5 | Analog output pin switches {core,hi,lo,bus1,bus2} |

## Verification
Decoded outputs react to a new instruction or a new boundary word at the TCK rising edge that leaves Update-IR or Update-DR. The bench drives TMS and TDI one time unit after each falling edge and samples outputs one time unit after the following rising edge, so each result is read in the cycle it first becomes valid. Serial data is read one time unit after each falling edge, where TDO has just changed. A read right after a shifting rising edge confirms TDO has not yet moved. Hold behaviour is checked in Pause-DR, after 14 new bits sit in the shift stage but before any update.

// File: rtl/mxs_scan_pkg.sv
package mxs_scan_pkg;
    localparam int IR_W   = 8;
    localparam int CELL_W = 4;
    localparam int IFC_W  = 4;
    localparam int N_ACELL = 2;
    localparam int BS_W   = IFC_W + N_ACELL * CELL_W + 2;
    localparam int SW_W   = 5;

    localparam logic [IR_W-1:0] OP_ISOLATE = 8'h00;
    localparam logic [IR_W-1:0] OP_PROBE   = 8'h01;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h02;
    localparam logic [IR_W-1:0] OP_BYPASS  = '1;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_st_e;

    typedef enum logic [1:0] {
        MODE_MISSION, MODE_PROBE, MODE_ISOLATE
    } cell_mode_e;
endpackage

// File: rtl/mxs_tap_fsm.sv
module mxs_tap_fsm
    import mxs_scan_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e state
);
    tap_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_RESET:  st_d = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   st_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: st_d = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: st_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  st_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: st_d = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: st_d = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: st_d = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: st_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: st_d = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: st_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  st_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: st_d = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: st_d = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: st_d = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: st_d = tms ? TS_SEL_DR : TS_IDLE;
            default:   st_d = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= TS_RESET;
        else         st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/mxs_instr_reg.sv
module mxs_instr_reg
    import mxs_scan_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  tap_st_e      state,
    output logic         ir_tdo,
    output logic [W-1:0] instr
);
    localparam logic [W-1:0] CAPT_PAT = W'(1);

    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] cur;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (state)
            TS_RESET:  r_d.cur = '1;
            TS_CAP_IR: r_d.sr  = CAPT_PAT;
            TS_SH_IR:  r_d.sr  = {tdi, r_q.sr[W-1:1]};
            TS_UPD_IR: r_d.cur = r_q.sr;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sr: '0, cur: '1};
        else         r_q <= r_d;
    end

    assign ir_tdo = r_q.sr[0];
    assign instr  = r_q.cur;
endmodule

// File: rtl/mxs_bound_reg.sv
module mxs_bound_reg
    import mxs_scan_pkg::*;
#(
    parameter int W = BS_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  tap_st_e      state,
    input  logic         sel,
    input  logic [W-1:0] cap_val,
    output logic         bs_tdo,
    output logic [W-1:0] lat
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] hold;
    } bs_t;

    bs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == TS_RESET) begin
            r_d.hold = '0;
        end else if (sel) begin
            unique case (state)
                TS_CAP_DR: r_d.sr   = cap_val;
                TS_SH_DR:  r_d.sr   = {tdi, r_q.sr[W-1:1]};
                TS_UPD_DR: r_d.hold = r_q.sr;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign bs_tdo = r_q.sr[0];
    assign lat    = r_q.hold;
endmodule

// File: rtl/mxs_cell_decode.sv
module mxs_cell_decode
    import mxs_scan_pkg::*;
(
    input  cell_mode_e        mode,
    input  logic [CELL_W-1:0] word,
    output logic [SW_W-1:0]   sw
);
    logic d_b, c_b, b1_b, b2_b;
    assign {d_b, c_b, b1_b, b2_b} = word;

    always_comb begin
        unique case (mode)
            MODE_ISOLATE: sw = {1'b0, c_b & d_b, c_b & ~d_b, b1_b, b2_b};
            MODE_PROBE:   sw = (d_b | c_b) ? 5'b10000 : {3'b100, b1_b, b2_b};
            default:      sw = 5'b10000;
        endcase
    end
endmodule

// File: rtl/mxs_scan_ctrl.sv
module mxs_scan_ctrl
    import mxs_scan_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic             ain_cmp,
    input  logic             aout_cmp,
    input  logic             dig_pin_in,
    input  logic             core_dout,
    output logic             core_din,
    output logic             dig_pin_out,
    output logic [IFC_W-1:0] ifc_ctl,
    output logic [SW_W-1:0]  ain_sw,
    output logic [SW_W-1:0]  aout_sw
);
    tap_st_e          tap_st;
    logic [IR_W-1:0]  instr;
    logic             ir_tdo, bs_tdo, sel_bsr;
    logic [BS_W-1:0]  bs_cap, bs_lat;
    cell_mode_e       mode;
    logic [N_ACELL-1:0][CELL_W-1:0] cell_w, cell_cmp;
    logic [N_ACELL-1:0][SW_W-1:0]   cell_sw;

    mxs_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st)
    );

    mxs_instr_reg #(.W(IR_W)) u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_st),
        .ir_tdo(ir_tdo), .instr(instr)
    );

    always_comb begin
        unique case (instr)
            OP_ISOLATE: mode = MODE_ISOLATE;
            OP_PROBE:   mode = MODE_PROBE;
            default:    mode = MODE_MISSION;
        endcase
    end
    assign sel_bsr = (instr == OP_ISOLATE) || (instr == OP_PROBE) || (instr == OP_SAMPLE);

    // cell 1 = analog input pin, cell 0 = analog output pin
    assign cell_cmp[1] = {ain_cmp,  {(CELL_W-1){1'b0}}};
    assign cell_cmp[0] = {aout_cmp, {(CELL_W-1){1'b0}}};
    assign bs_cap = {{IFC_W{1'b0}}, cell_cmp, dig_pin_in, core_dout};

    mxs_bound_reg #(.W(BS_W)) u_bsr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_st), .sel(sel_bsr),
        .cap_val(bs_cap), .bs_tdo(bs_tdo), .lat(bs_lat)
    );

    assign cell_w = bs_lat[BS_W-IFC_W-1:2];

    for (genvar g = 0; g < N_ACELL; g++) begin : g_acell
        mxs_cell_decode u_dec (
            .mode(mode), .word(cell_w[g]), .sw(cell_sw[g])
        );
    end

    assign ain_sw      = cell_sw[1];
    assign aout_sw     = cell_sw[0];
    assign ifc_ctl     = (mode == MODE_MISSION) ? '0 : bs_lat[BS_W-1 -: IFC_W];
    assign dig_pin_out = (mode == MODE_ISOLATE) ? bs_lat[0] : core_dout;
    assign core_din    = (mode == MODE_ISOLATE) ? bs_lat[1] : dig_pin_in;

    // bypass stage
    logic byp_d, byp_q;
    always_comb begin
        byp_d = byp_q;
        if (!sel_bsr && tap_st == TS_CAP_DR) byp_d = 1'b0;
        else if (!sel_bsr && tap_st == TS_SH_DR) byp_d = tdi;
    end
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) byp_q <= 1'b0;
        else         byp_q <= byp_d;
    end

    // falling-edge output stage
    typedef struct packed {
        logic dat;
        logic en;
    } out_t;
    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.en  = (tap_st == TS_SH_IR) || (tap_st == TS_SH_DR);
        if (tap_st == TS_SH_IR)      o_d.dat = ir_tdo;
        else if (tap_st == TS_SH_DR) o_d.dat = sel_bsr ? bs_tdo : byp_q;
    end
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo    = o_q.dat;
    assign tdo_en = o_q.en;
endmodule

// File: rtl/mxs_scan_chk.sv
module mxs_scan_chk
    import mxs_scan_pkg::*;
(
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input tap_st_e          state,
    input logic [IR_W-1:0]  instr,
    input logic [BS_W-1:0]  lat,
    input logic [SW_W-1:0]  ain_sw,
    input logic [SW_W-1:0]  aout_sw,
    input logic [IFC_W-1:0] ifc_ctl,
    input logic             tdo_en
);
    // R1: five TMS-high edges reach Test-Logic-Reset
    p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == TS_RESET);

    // R6: latches move only when leaving Update-DR (or clearing in reset state)
    p_hold_latch_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_UPD_DR && state != TS_RESET) |=> $stable(lat));

    // R7: isolate test never links a pin to the core
    p_isolate_core_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_ISOLATE) |-> (!ain_sw[4] && !aout_sw[4]));

    // R8: probe keeps the core linked with no drivers
    p_probe_core_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_PROBE) |-> (ain_sw[4:2] == 3'b100 && aout_sw[4:2] == 3'b100));

    // R9: mission modes leave buses and interface off
    p_mission_off_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (instr != OP_ISOLATE && instr != OP_PROBE) |-> (ifc_ctl == '0 && ain_sw == 5'b10000 && aout_sw == 5'b10000));

    // R10: output enable tracks the shift states
    p_tdo_en_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == TS_SH_IR || state == TS_SH_DR));
endmodule

bind mxs_scan_ctrl mxs_scan_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st), .instr(instr),
    .lat(bs_lat), .ain_sw(ain_sw), .aout_sw(aout_sw), .ifc_ctl(ifc_ctl), .tdo_en(tdo_en)
);

// File: tb/mxs_scan_ctrl_tb.sv
`timescale 1ns/1ps
module mxs_scan_ctrl_tb;
    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic ain_cmp = 1'b0, aout_cmp = 1'b0, dig_pin_in = 1'b0, core_dout = 1'b0;
    logic tdo, tdo_en, core_din, dig_pin_out;
    logic [3:0] ifc_ctl;
    logic [4:0] ain_sw, aout_sw;
    int n_chk = 0, n_bad = 0;

    always #2 tck = ~tck;

    mxs_scan_ctrl u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .ain_cmp(ain_cmp), .aout_cmp(aout_cmp), .dig_pin_in(dig_pin_in), .core_dout(core_dout),
        .core_din(core_din), .dig_pin_out(dig_pin_out), .ifc_ctl(ifc_ctl),
        .ain_sw(ain_sw), .aout_sw(aout_sw)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck); #1;
        o = tdo; e = tdo_en;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic go(input logic m);
        logic o, e;
        step(m, 1'b0, o, e);
    endtask

    task automatic load_ir(input logic [7:0] code, output logic [7:0] got);
        logic e;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 8; i++) step(i == 7, code[i], got[i], e);
        go(1); go(0);
    endtask

    // leaves the controller in Exit1-DR
    task automatic shift_dr(input int n, input logic [15:0] din, output logic [15:0] dout);
        logic e;
        dout = '0;
        go(1); go(0); go(0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], dout[i], e);
    endtask

    task automatic t_reset;
        logic o, e;
        #5 trst_n = 1'b1;
        go(0);
        chk("R1 ain_sw after trst", ain_sw, 5'b10000);
        chk("R1 aout_sw after trst", aout_sw, 5'b10000);
        chk("R1 ifc_ctl after trst", ifc_ctl, 4'h0);
        chk("R10 tdo_en idle", tdo_en, 1'b0);
        // bypass after reset, pattern 1,0,1,1
        go(1); go(0); go(0);
        step(1'b0, 1'b1, o, e);
        chk("R3 bypass capture 0", o, 1'b0);
        chk("R10 tdo_en in shift", e, 1'b1);
        chk("R10 tdo still old after rising edge", tdo, 1'b0);
        step(1'b0, 1'b0, o, e);
        chk("R3 bypass delay bit1", o, 1'b1);
        step(1'b0, 1'b1, o, e);
        chk("R3 bypass delay bit2", o, 1'b0);
        step(1'b1, 1'b1, o, e);
        chk("R3 bypass delay bit3", o, 1'b1);
        go(1); go(0);
        chk("R10 tdo_en after update", tdo_en, 1'b0);
    endtask

    task automatic t_ir_capture;
        logic [7:0] got;
        load_ir(8'h02, got);
        chk("R2 ir capture pattern", got, 8'h01);
    endtask

    task automatic t_sample_preload;
        logic [15:0] out;
        logic [13:0] pre = {4'b1010, 4'b1101, 4'b0110, 1'b1, 1'b1};
        ain_cmp = 1'b1; aout_cmp = 1'b0; dig_pin_in = 1'b1; core_dout = 1'b0;
        shift_dr(14, {2'b00, pre}, out);
        go(1); go(0);
        chk("R4 R5 boundary capture", out[13:0], {4'b0000, 4'b1000, 4'b0000, 1'b1, 1'b0});
        chk("R9 sample ain_sw mission", ain_sw, 5'b10000);
        chk("R9 sample ifc_ctl zero", ifc_ctl, 4'h0);
        chk("R9 sample dig_pin_out transparent", dig_pin_out, 1'b0);
        chk("R9 sample core_din transparent", core_din, 1'b1);
    endtask

    task automatic t_isolate;
        logic [7:0] got;
        logic [15:0] out;
        logic [13:0] nxt = {4'b0001, 4'b0010, 4'b1110, 1'b0, 1'b0};
        dig_pin_in = 1'b0; core_dout = 1'b0;
        load_ir(8'h00, got);
        chk("R7 ain_sw C&D drives hi, B2", ain_sw, 5'b01001);
        chk("R7 aout_sw C&~D drives lo, B1", aout_sw, 5'b00110);
        chk("R7 ifc_ctl latched", ifc_ctl, 4'b1010);
        chk("R7 dig_pin_out latched", dig_pin_out, 1'b1);
        chk("R7 core_din latched", core_din, 1'b1);
        ain_cmp = 1'b0; aout_cmp = 1'b1;
        shift_dr(14, {2'b00, nxt}, out);
        chk("R5 capture under isolate", out[13:0], {4'b0000, 4'b0000, 4'b1000, 1'b0, 1'b0});
        go(0);
        chk("R6 ain_sw held in pause", ain_sw, 5'b01001);
        chk("R6 ifc_ctl held in pause", ifc_ctl, 4'b1010);
        go(1); go(1); go(0);
        chk("R6 R7 ain_sw after update", ain_sw, 5'b00010);
        chk("R6 R7 aout_sw after update", aout_sw, 5'b01010);
        chk("R7 ifc_ctl after update", ifc_ctl, 4'b0001);
        chk("R7 dig_pin_out after update", dig_pin_out, 1'b0);
    endtask

    task automatic t_tms_reset;
        go(1); go(1); go(1); go(1); go(1);
        chk("R1 tms reset ain_sw", ain_sw, 5'b10000);
        chk("R1 tms reset ifc_ctl", ifc_ctl, 4'h0);
        go(0);
        core_dout = 1'b1; #1;
        chk("R1 tms reset dig transparent", dig_pin_out, 1'b1);
    endtask

    task automatic t_probe;
        logic [7:0] got;
        logic [15:0] out;
        logic [13:0] w = {4'b0101, 4'b0011, 4'b1001, 1'b0, 1'b0};
        load_ir(8'h01, got);
        chk("R8 probe after reset cleared", ain_sw, 5'b10000);
        shift_dr(14, {2'b00, w}, out);
        go(1); go(0);
        chk("R8 probe ain buses", ain_sw, 5'b10011);
        chk("R8 probe aout D set core only", aout_sw, 5'b10000);
        chk("R8 probe ifc_ctl", ifc_ctl, 4'b0101);
        chk("R8 probe dig_pin_out transparent", dig_pin_out, 1'b1);
        dig_pin_in = 1'b1; #1;
        chk("R8 probe core_din transparent", core_din, 1'b1);
    endtask

    task automatic t_unknown;
        logic [7:0] got;
        logic [15:0] out;
        load_ir(8'h55, got);
        chk("R9 unknown code mission", ain_sw, 5'b10000);
        shift_dr(3, 16'b011, out);
        go(1); go(0);
        chk("R3 unknown code bypass path", out[2:0], 3'b110);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ir_capture();
        t_sample_preload();
        t_isolate();
        t_tms_reset();
        t_probe();
        t_unknown();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule